// File: doc/BRIEF.md
# Predicated Execute and Writeback Stage

This block is the execute and writeback stage of a small single-issue register machine whose instructions can be predicated. It holds sixteen 32-bit integer registers and sixteen one-bit predicate registers. A decoded operation is presented on flat input fields for one cycle. The stage reads its operands, works out the guard that decides whether the operation may take effect, and drives the register or predicate write one cycle later on its writeback port. Loads use a synchronous data memory read port, and the memory returns the data one cycle after the request.

Every operation names a guarding predicate. Predicate 0 always reads 1, so an unconditional operation simply names predicate 0 as its guard. Some operations also have a data condition of their own: the conditional move needs a zero test register, and the conditional load needs a nonzero test register. When the guard or the condition fails, the operation leaves no trace. It makes no register write, no predicate write and no memory request. This turns a short branch into a data dependence. Absolute value, for example, is built from a compare, an unconditional add of zero, and a negating conditional move guarded by the compare result.

Top module: `pex_stage`

## Requirements
- R1: While reset is held and in the first cycle after it, rfWrEn, prWrEn and memRdEn are all 0. After reset every integer register holds 0 and predicates 1 to 15 hold 0.
- R2: The compare (opKind 1) writes predicate opPd with 1 when register opRs2 is less than or equal to register opRs1, compared as signed 32-bit values, and with 0 otherwise.
- R3: When the guard predicate opPg reads 0, the operation makes no integer write, no predicate write and no memory read, whatever its kind.
- R4: The conditional move (opKind 2) writes register opRs1 to opRd only when register opRs3 equals zero. When opNeg is 1 it writes the two's complement negation of opRs1 instead.
- R5: The predicated add (opKind 3) writes opRs1 plus a second operand to opRd. The second operand is register opRs2 when opUseImm is 0, and the sign-extended 12-bit opOffset when opUseImm is 1.
- R6: The conditional load (opKind 4) raises memRdEn in the cycle the operation is presented, with memAddr equal to opRs1 plus the sign-extended opOffset, and one cycle later writes the returned memRdata to opRd. When register opRs3 is zero, memRdEn stays 0 and there is no write.
- R7: Predicate 0 always reads 1. A compare that targets predicate 0 raises no predicate write.
- R8: Integer register 0 always reads 0. An operation that targets register 0 raises no integer write.
- R9: An operation that reads a register or predicate written by the operation just before it sees the new value.
- R10: A result appears on the writeback port in the cycle after its operation is presented. A cycle with opValid 0, or with opKind 0, produces no write in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Decoded operation present this cycle |
| opKind | input | 3 | 0 none, 1 compare, 2 conditional move, 3 predicated add, 4 conditional load |
| opRd | input | 4 | Integer destination register |
| opRs1 | input | 4 | First source register |
| opRs2 | input | 4 | Second source register |
| opRs3 | input | 4 | Zero-test register for move and load |
| opPd | input | 4 | Predicate destination for the compare |
| opPg | input | 4 | Guarding predicate |
| opNeg | input | 1 | Conditional move writes the negated source |
| opUseImm | input | 1 | Add uses the offset in place of opRs2 |
| opOffset | input | 12 | Signed offset or immediate |
| memRdEn | output | 1 | Data memory read request |
| memAddr | output | 32 | Data memory read address |
| memRdata | input | 32 | Read data, valid the cycle after the request |
| rfWrEn | output | 1 | Integer register write |
| rfWrAddr | output | 4 | Integer register written |
| rfWrData | output | 32 | Value written |
| prWrEn | output | 1 | Predicate register write |
| prWrAddr | output | 4 | Predicate written |
| prWrData | output | 1 | Predicate value written |

## Verification
The hardest case to reach is back-to-back dependence. Examples are a guard that reads a predicate produced one cycle earlier, or a load address that depends on load data still arriving from memory. Here only the bypass path gives the right answer. Since every register starts at zero, the stimulus first seeds values with immediate adds and loads. Random operations then draw their register and predicate indices from a narrow range, so consecutive operations collide often. A directed absolute-value sequence also chains a compare into a negating move guarded by its result.

// File: rtl/pex_pkg.sv
package pex_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_CMOVZ = 3'd2,
    OP_PADD  = 3'd3,
    OP_LDNZ  = 3'd4
  } opKind_e;

  typedef struct packed {
    logic rfWe;
    logic prWe;
    logic memRe;
    logic selLoad;
    logic selMove;
  } strobe_t;

endpackage

// File: rtl/pex_control.sv
module pex_control
  import pex_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic       guardVal,
  input  logic       condZero,
  input  logic       rdZero,
  input  logic       pdZero,
  output strobe_t    stb
);

  opKind_e kind;
  assign kind = opKind_e'(opKind);

  always_comb begin
    stb = '0;
    if (opValid && guardVal) begin
      unique case (kind)
        OP_CMP:   stb.prWe = !pdZero;
        OP_CMOVZ: begin
          stb.selMove = 1'b1;
          stb.rfWe    = condZero && !rdZero;
        end
        OP_PADD:  stb.rfWe = !rdZero;
        OP_LDNZ:  begin
          stb.selLoad = 1'b1;
          stb.memRe   = !condZero;
          stb.rfWe    = !condZero && !rdZero;
        end
        default:  stb = '0;
      endcase
    end
  end

  // A failed guard squashes every effect of the operation.
  assert_guard_squash_R3: assert property (@(posedge clk) disable iff (rst)
    !guardVal |-> (!stb.rfWe && !stb.prWe && !stb.memRe));

  // A load request is never issued against a zero test register.
  assert_load_gate_R6: assert property (@(posedge clk) disable iff (rst)
    stb.memRe |-> !condZero);

endmodule

// File: rtl/pex_datapath.sv
module pex_datapath
  import pex_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 16,
  parameter int NPRED = 16,
  parameter int OFFW  = 12,
  parameter int RAW   = $clog2(NREG),
  parameter int PAW   = $clog2(NPRED)
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  opRd,
  input  logic [RAW-1:0]  opRs1,
  input  logic [RAW-1:0]  opRs2,
  input  logic [RAW-1:0]  opRs3,
  input  logic [PAW-1:0]  opPd,
  input  logic [PAW-1:0]  opPg,
  input  logic            opNeg,
  input  logic            opUseImm,
  input  logic [OFFW-1:0] opOffset,
  input  strobe_t         stb,
  output logic            guardVal,
  output logic            condZero,
  output logic            rdZero,
  output logic            pdZero,
  output logic [XLEN-1:0] memAddr,
  input  logic [XLEN-1:0] memRdata,
  output logic            rfWrEn,
  output logic [RAW-1:0]  rfWrAddr,
  output logic [XLEN-1:0] rfWrData,
  output logic            prWrEn,
  output logic [PAW-1:0]  prWrAddr,
  output logic            prWrData
);

  localparam int NSRC = 3;

  logic [XLEN-1:0] regs [NREG];
  logic [NPRED-1:0] preds;

  // writeback stage state
  logic            wbRfWe, wbPrWe, wbLoad, wbPv;
  logic [RAW-1:0]  wbRd;
  logic [PAW-1:0]  wbPd;
  logic [XLEN-1:0] wbVal, wbData;

  assign wbData = wbLoad ? memRdata : wbVal;

  // operand read ports with bypass from writeback
  logic [RAW-1:0]  srcAddr [NSRC];
  logic [XLEN-1:0] srcData [NSRC];
  assign srcAddr[0] = opRs1;
  assign srcAddr[1] = opRs2;
  assign srcAddr[2] = opRs3;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign srcData[s] = (srcAddr[s] == '0) ? '0 :
                        (wbRfWe && wbRd == srcAddr[s]) ? wbData :
                        regs[srcAddr[s]];
  end

  assign guardVal = (opPg == '0) ? 1'b1 :
                    (wbPrWe && wbPd == opPg) ? wbPv : preds[opPg];

  logic [XLEN-1:0] opA, opB, opC, offExt, addend, moveVal, exVal;
  logic            cmpRes;

  assign opA     = srcData[0];
  assign opB     = srcData[1];
  assign opC     = srcData[2];
  assign offExt  = {{(XLEN-OFFW){opOffset[OFFW-1]}}, opOffset};
  assign addend  = opUseImm ? offExt : opB;
  assign cmpRes  = $signed(opB) <= $signed(opA);
  assign moveVal = opNeg ? (~opA + XLEN'(1)) : opA;
  assign exVal   = stb.selMove ? moveVal : (opA + addend);
  assign memAddr = opA + offExt;
  assign condZero = (opC == '0);
  assign rdZero   = (opRd == '0);
  assign pdZero   = (opPd == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbRfWe <= 1'b0;
      wbPrWe <= 1'b0;
      wbLoad <= 1'b0;
      wbPv   <= 1'b0;
      wbRd   <= '0;
      wbPd   <= '0;
      wbVal  <= '0;
    end else begin
      wbRfWe <= stb.rfWe;
      wbPrWe <= stb.prWe;
      wbLoad <= stb.selLoad;
      wbPv   <= cmpRes;
      wbRd   <= opRd;
      wbPd   <= opPd;
      wbVal  <= exVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wbRfWe && wbRd != '0) begin
      regs[wbRd] <= wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) preds <= NPRED'(1);
    else if (wbPrWe && wbPd != '0) preds[wbPd] <= wbPv;
  end

  assign rfWrEn   = wbRfWe;
  assign rfWrAddr = wbRd;
  assign rfWrData = wbData;
  assign prWrEn   = wbPrWe;
  assign prWrAddr = wbPd;
  assign prWrData = wbPv;

  assert_r0_untouched_R8: assert property (@(posedge clk) disable iff (rst)
    rfWrEn |-> rfWrAddr != '0);

  assert_p0_untouched_R7: assert property (@(posedge clk) disable iff (rst)
    prWrEn |-> prWrAddr != '0);

  assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
    !(rfWrEn && prWrEn));

  assert_load_had_request_R6: assert property (@(posedge clk) disable iff (rst)
    stb.memRe |=> (rfWrEn || rfWrAddr == '0));

endmodule

// File: rtl/pex_stage.sv
module pex_stage
  import pex_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 16,
  parameter int NPRED = 16,
  parameter int OFFW  = 12,
  localparam int RAW  = $clog2(NREG),
  localparam int PAW  = $clog2(NPRED)
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            opValid,
  input  logic [2:0]      opKind,
  input  logic [RAW-1:0]  opRd,
  input  logic [RAW-1:0]  opRs1,
  input  logic [RAW-1:0]  opRs2,
  input  logic [RAW-1:0]  opRs3,
  input  logic [PAW-1:0]  opPd,
  input  logic [PAW-1:0]  opPg,
  input  logic            opNeg,
  input  logic            opUseImm,
  input  logic [OFFW-1:0] opOffset,
  output logic            memRdEn,
  output logic [XLEN-1:0] memAddr,
  input  logic [XLEN-1:0] memRdata,
  output logic            rfWrEn,
  output logic [RAW-1:0]  rfWrAddr,
  output logic [XLEN-1:0] rfWrData,
  output logic            prWrEn,
  output logic [PAW-1:0]  prWrAddr,
  output logic            prWrData
);

  strobe_t stb;
  logic guardVal, condZero, rdZero, pdZero;

  pex_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opKind   (opKind),
    .guardVal (guardVal),
    .condZero (condZero),
    .rdZero   (rdZero),
    .pdZero   (pdZero),
    .stb      (stb)
  );

  pex_datapath #(
    .XLEN(XLEN), .NREG(NREG), .NPRED(NPRED), .OFFW(OFFW), .RAW(RAW), .PAW(PAW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .opRd     (opRd),
    .opRs1    (opRs1),
    .opRs2    (opRs2),
    .opRs3    (opRs3),
    .opPd     (opPd),
    .opPg     (opPg),
    .opNeg    (opNeg),
    .opUseImm (opUseImm),
    .opOffset (opOffset),
    .stb      (stb),
    .guardVal (guardVal),
    .condZero (condZero),
    .rdZero   (rdZero),
    .pdZero   (pdZero),
    .memAddr  (memAddr),
    .memRdata (memRdata),
    .rfWrEn   (rfWrEn),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .prWrEn   (prWrEn),
    .prWrAddr (prWrAddr),
    .prWrData (prWrData)
  );

  assign memRdEn = stb.memRe;

  // An empty issue slot leaves the writeback port idle next cycle.
  assert_idle_slot_R10: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> (!rfWrEn && !prWrEn));

  assert_request_needs_op_R6: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> (opValid && opKind == 3'd4));

endmodule

// File: tb/tb_pex_stage.sv
module tb_pex_stage;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = '0;
  logic [3:0]  opRd = '0, opRs1 = '0, opRs2 = '0, opRs3 = '0, opPd = '0, opPg = '0;
  logic        opNeg = 1'b0, opUseImm = 1'b0;
  logic [11:0] opOffset = '0;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic [31:0] memRdata = '0;
  logic        rfWrEn;
  logic [3:0]  rfWrAddr;
  logic [31:0] rfWrData;
  logic        prWrEn;
  logic [3:0]  prWrAddr;
  logic        prWrData;

  pex_stage dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opKind(opKind), .opRd(opRd),
    .opRs1(opRs1), .opRs2(opRs2), .opRs3(opRs3), .opPd(opPd), .opPg(opPg),
    .opNeg(opNeg), .opUseImm(opUseImm), .opOffset(opOffset),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdata(memRdata),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .prWrEn(prWrEn), .prWrAddr(prWrAddr), .prWrData(prWrData)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  always @(posedge clk) if (memRdEn) memRdata <= memFn(memAddr);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] rm [16];
  logic        pm [16];

  logic        expRfWe, expPrWe, expPv;
  logic [3:0]  expRd, expPd;
  logic [31:0] expVal;
  string       expTag;
  logic [3:0]  lastRd, lastPd;
  logic        lastRfWe, lastPrWe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkWb();
    chk({expTag, " rfWrEn"}, 32'(rfWrEn), 32'(expRfWe));
    if (expRfWe) begin
      chk({expTag, " rfWrAddr"}, 32'(rfWrAddr), 32'(expRd));
      chk({expTag, " rfWrData"}, rfWrData, expVal);
    end
    chk({expTag, " prWrEn"}, 32'(prWrEn), 32'(expPrWe));
    if (expPrWe) begin
      chk({expTag, " prWrAddr"}, 32'(prWrAddr), 32'(expPd));
      chk({expTag, " prWrData"}, 32'(prWrData), 32'(expPv));
    end
  endtask

  // Called just after a falling edge: checks the previous operation's
  // writeback, presents a new operation and checks its memory request.
  task automatic issue(input logic v, input logic [2:0] k, input logic [3:0] rd,
                       input logic [3:0] s1, input logic [3:0] s2, input logic [3:0] s3,
                       input logic [3:0] pd, input logic [3:0] pg, input logic neg,
                       input logic useImm, input logic [11:0] off);
    logic [31:0] a, b, c, offx, addr;
    logic g, expMem;
    string tag;
    checkWb();
    opValid = v; opKind = k; opRd = rd; opRs1 = s1; opRs2 = s2; opRs3 = s3;
    opPd = pd; opPg = pg; opNeg = neg; opUseImm = useImm; opOffset = off;
    #1;
    a = rm[s1]; b = rm[s2]; c = rm[s3]; g = pm[pg];
    offx = {{20{off[11]}}, off};
    addr = a + offx;
    expMem = 1'b0; expRfWe = 1'b0; expPrWe = 1'b0;
    expRd = rd; expPd = pd; expVal = '0; expPv = 1'b0;
    tag = "R10";
    if (v) begin
      case (k)
        3'd1: tag = (pd == 0) ? "R7" : "R2";
        3'd2: tag = "R4";
        3'd3: tag = "R5";
        3'd4: tag = "R6";
        default: tag = "R10";
      endcase
      if (k >= 3'd2 && k <= 3'd4 && rd == 0) tag = "R8";
      if ((lastRfWe && lastRd != 0 && (lastRd == s1 || lastRd == s2 || lastRd == s3)) ||
          (lastPrWe && lastPd != 0 && lastPd == pg)) tag = "R9";
      if (!g) tag = "R3";
    end
    if (v && g) begin
      case (k)
        3'd1: if (pd != 0) begin expPrWe = 1'b1; expPv = ($signed(b) <= $signed(a)); end
        3'd2: if (c == 0 && rd != 0) begin expRfWe = 1'b1; expVal = neg ? -a : a; end
        3'd3: if (rd != 0) begin expRfWe = 1'b1; expVal = a + (useImm ? offx : b); end
        3'd4: if (c != 0) begin
                expMem = 1'b1;
                if (rd != 0) begin expRfWe = 1'b1; expVal = memFn(addr); end
              end
        default: ;
      endcase
    end
    chk({tag, " memRdEn (R6)"}, 32'(memRdEn), 32'(expMem));
    if (expMem) chk("R6 memAddr", memAddr, addr);
    if (expRfWe) rm[rd] = expVal;
    if (expPrWe) pm[pd] = expPv;
    lastRfWe = expRfWe; lastRd = rd; lastPrWe = expPrWe; lastPd = pd;
    expTag = tag;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin rm[i] = '0; pm[i] = (i == 0); end
    expRfWe = 0; expPrWe = 0; expPv = 0; expRd = 0; expPd = 0; expVal = 0;
    lastRfWe = 0; lastPrWe = 0; lastRd = 0; lastPd = 0;
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    chk("R1 rfWrEn in reset", 32'(rfWrEn), 0);
    chk("R1 memRdEn in reset", 32'(memRdEn), 0);
    rst = 1'b0;
    @(negedge clk);
    expTag = "R1";
    // predicate 0 target, then register 0 target
    issue(1, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 12'd0);
    issue(1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 1, 12'd5);
    issue(1, 3'd3, 1, 0, 0, 0, 0, 0, 0, 1, 12'd0);
    // absolute value of -7 through a forwarded predicate
    issue(1, 3'd3, 5, 0, 0, 0, 0, 0, 0, 1, 12'hFF9);
    issue(1, 3'd1, 0, 0, 5, 0, 5, 0, 0, 0, 12'd0);
    issue(1, 3'd3, 6, 5, 0, 0, 0, 0, 0, 1, 12'd0);
    issue(1, 3'd2, 6, 5, 0, 0, 0, 5, 1, 0, 12'd0);
    issue(1, 3'd3, 9, 6, 0, 0, 0, 0, 0, 0, 12'd0);
    // false guard squashes add and load
    issue(1, 3'd3, 7, 0, 0, 0, 0, 0, 0, 1, 12'd9);
    issue(1, 3'd1, 0, 0, 7, 0, 4, 0, 0, 0, 12'd0);
    issue(1, 3'd3, 8, 7, 7, 0, 0, 4, 0, 0, 12'd0);
    issue(1, 3'd4, 8, 7, 0, 7, 0, 4, 0, 0, 12'd4);
    // zero and nonzero test registers
    issue(1, 3'd4, 10, 7, 0, 0, 0, 0, 0, 0, 12'd16);
    issue(1, 3'd4, 10, 7, 0, 7, 0, 0, 0, 0, 12'd16);
    issue(1, 3'd4, 11, 10, 0, 10, 0, 0, 0, 0, 12'hFFC);
    issue(1, 3'd2, 12, 7, 0, 7, 0, 0, 0, 0, 12'd0);
    issue(1, 3'd2, 12, 7, 0, 0, 0, 0, 0, 0, 12'd0);
    issue(0, 3'd3, 13, 7, 7, 0, 0, 0, 0, 0, 12'd0);
    issue(1, 3'd0, 13, 7, 7, 0, 0, 0, 0, 0, 12'd0);
    // random mix with dense register reuse
    for (int n = 0; n < 600; n++) begin
      logic v;
      logic [3:0] pg;
      v  = ($urandom_range(0, 9) != 0);
      pg = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 7));
      issue(v, 3'($urandom_range(0, 4)), 4'($urandom_range(0, 7)),
            4'($urandom_range(0, 7)), 4'($urandom_range(0, 7)), 4'($urandom_range(0, 3)),
            4'($urandom_range(0, 7)), pg, 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)));
    end
    issue(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 12'd0);
    checkWb();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule